// File: doc/BRIEF.md
# Modular Butterfly Processing Element

This block is the arithmetic core of a number-theoretic transform over the prime field of modulus 3329. That field is used by lattice-based key encapsulation on polynomials of 256 coefficients. Each cycle it can take one coefficient pair (a, b) and one twiddle factor. It returns the Cooley-Tukey butterfly results a + w·b and a − w·b, both fully reduced into the range 0 to 3328.

The twiddle product is formed in a pipelined multiplier. It is brought back into the field with Montgomery reduction, using a radix of 2^16. For this reason the twiddle factor must be supplied already scaled, as w·2^16 mod 3329. The sum and the difference are then each reduced by a Barrett step. The difference path adds the modulus first, so it never goes negative.

A single valid strobe travels with the data through four register stages. Memories, twiddle storage and stage sequencing belong to the surrounding transform controller.

Top module: `ntt_butterfly_pe`

## Requirements
- R1: When a butterfly with coefficients a, b and scaled twiddle input t = (w·65536) mod 3329 is accepted, out_sum later equals (a + w·b) mod 3329.
- R2: For the same butterfly, out_dif equals (a − w·b) mod 3329, taken in the range 0 to 3328.
- R3: Whenever out_valid is high, out_sum and out_dif both lie in 0 to 3328, including at the extreme inputs 0 and 3328.
- R4: Latency is fixed. Inputs sampled at a rising edge with in_valid high appear at the outputs, with out_valid high, just after the fourth rising edge counting that one. out_valid is in_valid delayed by four edges.
- R5: One butterfly is accepted on every cycle. Back-to-back inputs produce back-to-back results in the same order.
- R6: While rst_n is low (active low), and after it is released with no input, out_valid is 0 and both outputs are 0. This holds even when data was in flight.
- R7: While out_valid is low, out_sum and out_dif keep the last result.
- R8: Inputs presented with in_valid low are ignored. They produce no out_valid pulse and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; data is sampled when high |
| in_a | input | 12 | First coefficient, below 3329 |
| in_b | input | 12 | Second coefficient, below 3329 |
| in_w | input | 12 | Twiddle factor in Montgomery form (w·2^16 mod 3329) |
| out_valid | output | 1 | Result strobe |
| out_sum | output | 12 | (a + w·b) mod 3329 |
| out_dif | output | 12 | (a − w·b) mod 3329 |

## Verification
The assertions take it as given that every accepted coefficient and twiddle value is already below 3329. They check this assumption separately, because the single final subtraction in each reducer relies on it. The stimulus table holds only normal-form values in 0 to 3328, with the extremes 0, 1 and 3328 included. The bench converts each twiddle into the scaled form before driving it. Values driven with in_valid low may be out of range, because the block must ignore them.

// File: rtl/ntt_butterfly_pe.sv
module ntt_butterfly_pe #(
  parameter int Q  = 3329,
  parameter int W  = 12,
  parameter int RB = 16,
  parameter int BK = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_w,
  output logic         out_valid,
  output logic [W-1:0] out_sum,
  output logic [W-1:0] out_dif
);

  function automatic longint neg_inv(longint q, int rb);
    longint m, inv;
    m = longint'(1) << rb;
    inv = q;
    for (int i = 0; i < 6; i++)
      inv = (inv * (2 - ((q * inv) & (m - 1)))) & (m - 1);
    return (m - inv) & (m - 1);
  endfunction

  localparam int           TW = RB + W + 1;
  localparam logic [W:0]   QE = (W+1)'(Q);
  localparam logic [RB-1:0] QP = RB'(neg_inv(longint'(Q), RB));
  localparam logic [W+BK:0] BM = (W+BK+1)'((longint'(1) << BK) / Q);

  function automatic logic [W-1:0] barrett(input logic [W:0] x);
    logic [W+BK:0] prod;
    logic [W:0]    qh, r;
    prod = (W+BK+1)'(x) * BM;
    qh   = prod[BK +: W+1];
    r    = x - (W+1)'(qh * QE);
    return (r >= QE) ? W'(r - QE) : W'(r);
  endfunction

  logic         v1, v2, v3;
  logic [W-1:0] a1, b1, w1, a2, a3, r3;
  logic [2*W-1:0] p2;

  logic [RB-1:0] m_lo;
  logic [TW-1:0] tsum;
  logic [W:0]    tq;
  logic [W-1:0]  mont;
  logic [W:0]    sum3, dif3;

  assign m_lo = RB'(p2[RB-1:0] * QP);
  assign tsum = TW'(p2) + TW'(m_lo) * TW'(Q);
  assign tq   = tsum[TW-1:RB];
  assign mont = (tq >= QE) ? W'(tq - QE) : W'(tq);
  assign sum3 = {1'b0, a3} + {1'b0, r3};
  assign dif3 = {1'b0, a3} + QE - {1'b0, r3};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; out_valid <= 1'b0;
      a1 <= '0; b1 <= '0; w1 <= '0;
      a2 <= '0; p2 <= '0;
      a3 <= '0; r3 <= '0;
      out_sum <= '0; out_dif <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      out_valid <= v3;
      if (in_valid) begin
        a1 <= in_a; b1 <= in_b; w1 <= in_w;
      end
      if (v1) begin
        a2 <= a1;
        p2 <= w1 * b1;
      end
      if (v2) begin
        a3 <= a2;
        r3 <= mont;
      end
      if (v3) begin
        out_sum <= barrett(sum3);
        out_dif <= barrett(dif3);
      end
    end
  end

endmodule

module ntt_butterfly_pe_chk #(
  parameter int Q = 3329,
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [W-1:0] in_w,
  input logic         out_valid,
  input logic [W-1:0] out_sum,
  input logic [W-1:0] out_dif
);

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  p_in_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(in_a) < Q && int'(in_b) < Q && int'(in_w) < Q));

  p_out_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sum) < Q && int'(out_dif) < Q));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  p_pair_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && out_valid) |->
      ((int'(out_sum) + int'(out_dif)) % Q == (2 * int'($past(in_a, 4))) % Q));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && !out_valid) |-> ($stable(out_sum) && $stable(out_dif)));

endmodule

bind ntt_butterfly_pe ntt_butterfly_pe_chk #(.Q(Q), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_a(in_a), .in_b(in_b), .in_w(in_w),
  .out_valid(out_valid), .out_sum(out_sum), .out_dif(out_dif)
);

// File: tb/ntt_butterfly_pe_tb.sv
module ntt_butterfly_pe_tb;
  localparam int Q = 3329;
  localparam int NV = 12;
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{3328, 3328, 3328}, '{0, 1, 1}, '{3328, 0, 5},
    '{3328, 1, 1}, '{1, 3328, 3328}, '{1234, 2345, 17}, '{2000, 3000, 1729},
    '{5, 3327, 2}, '{3000, 1500, 3328}, '{42, 4, 1664}, '{1664, 1665, 3000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_a = '0, in_b = '0, in_w = '0;
  logic        out_valid;
  logic [11:0] out_sum, out_dif;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ntt_butterfly_pe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_w(in_w),
    .out_valid(out_valid), .out_sum(out_sum), .out_dif(out_dif)
  );

  function automatic int exp_sum(int a, int b, int w);
    return (a + (w * b) % Q) % Q;
  endfunction
  function automatic int exp_dif(int a, int b, int w);
    return (a - (w * b) % Q + Q) % Q;
  endfunction
  function automatic int to_mont(int w);
    return (w * 65536) % Q;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit v, int a, int b, int w);
    in_valid = v;
    in_a = 12'(a);
    in_b = 12'(b);
    in_w = 12'(w);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hs, hd;
    repeat (3) @(negedge clk);
    check("R6 valid in reset", int'(out_valid), 0);
    check("R6 sum in reset", int'(out_sum), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 valid after release", int'(out_valid), 0);
    check("R6 dif after release", int'(out_dif), 0);

    // R5 stream the table back to back; R1 R2 R3 per entry
    for (int j = 0; j < NV + 5; j++) begin
      if (j > 0) @(negedge clk);
      if (j >= 4 && j - 4 < NV) begin
        check("R5 stream valid", int'(out_valid), 1);
        check("R1 sum", int'(out_sum), exp_sum(VEC[j-4][0], VEC[j-4][1], VEC[j-4][2]));
        check("R2 dif", int'(out_dif), exp_dif(VEC[j-4][0], VEC[j-4][1], VEC[j-4][2]));
        check("R3 range", int'(out_sum < 12'(Q) && out_dif < 12'(Q)), 1);
      end else begin
        check("R4 no early valid", int'(out_valid), 0);
      end
      if (j < NV) drive(1'b1, VEC[j][0], VEC[j][1], to_mont(VEC[j][2]));
      else drive(1'b0, 0, 0, 0);
      @(posedge clk);
    end

    // R4 single butterfly latency
    @(negedge clk);
    drive(1'b1, 100, 200, to_mont(300));
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      drive(1'b0, 0, 0, 0);
      check("R4 latency valid", int'(out_valid), (k == 4) ? 1 : 0);
      if (k == 4) begin
        check("R1 single sum", int'(out_sum), exp_sum(100, 200, 300));
        check("R2 single dif", int'(out_dif), exp_dif(100, 200, 300));
      end
    end
    hs = exp_sum(100, 200, 300);
    hd = exp_dif(100, 200, 300);

    // R7 hold during idle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 hold sum", int'(out_sum), hs);
      check("R7 hold dif", int'(out_dif), hd);
    end

    // R8 ignored inputs with in_valid low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      drive(1'b0, 4000 - k, 3100 + k, 4095);
      if (k > 0) begin
        check("R8 no valid", int'(out_valid), 0);
        check("R8 sum unchanged", int'(out_sum), hs);
        check("R8 dif unchanged", int'(out_dif), hd);
      end
    end

    // R6 reset with data in flight
    @(negedge clk);
    drive(1'b1, 7, 8, to_mont(9));
    @(negedge clk);
    drive(1'b1, 10, 11, to_mont(12));
    @(negedge clk);
    drive(1'b0, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6 flushed valid", int'(out_valid), 0);
      check("R6 flushed sum", int'(out_sum), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule